// File: doc/BRIEF.md
# GPIO Bank With Edge-Capture Interrupt Status

A memory-mapped controller for a single bank of general-purpose pins. Each pin is either an input or an output, chosen by a direction register. Outputs drive the value held in an output latch. Software can write that latch as a whole word, or change individual bits through write-one-to-set and write-one-to-clear aliases. Every pin level, including the level of pins that are being driven, is brought into the clock domain by a multi-flop synchronizer before it can be read back.

Each pin can watch for rising edges, falling edges, or both. The two enable masks can be changed only through their own set and clear aliases, so a mask is never rewritten as a whole. An enabled edge on the synchronized level sets a sticky status bit. Software clears that bit by writing a one to it. A parent interrupt controller, which lies outside this block, combines the status bits.

Access uses a simple word-wide register bus. A cycle with `bus_sel` and `bus_wr` high is a write. Read data is combinational from the address while `bus_sel` is high. Registers sit on word boundaries, and an access with nonzero low address bits is ignored and reads as zero.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every direction bit is 1, so all pins are inputs and `pin_oe` is 0. The output latch, both edge-enable masks and the status register are all 0.
- R2: A direction bit of 1 makes its pin an input, with `pin_oe` low. A 0 makes `pin_oe` high for that pin. `pin_out` always carries the output latch.
- R3: The direction register is at byte 0x00 and the output latch at byte 0x04. Both are written and read as whole words.
- R4: A write to set-data (0x08) sets the latch bits that are 1 in the data word. A write to clear-data (0x0C) clears the latch bits that are 1. Bits that are 0 in the data word leave the latch unchanged. A read of 0x08 returns the latch.
- R5: A read of input data (0x10) returns the pin level after a two-flop synchronizer. A pin change made just before a clock edge is not visible after one edge and is visible after two. Writes to 0x10 have no effect.
- R6: The rising-enable mask is set through 0x14 and cleared through 0x18. The falling-enable mask is set through 0x1C and cleared through 0x20. Each write affects only the bits that are 1. Reads of 0x14 and 0x1C return the current masks.
- R7: The clear-alias addresses 0x0C, 0x18 and 0x20 read as zero.
- R8: A rising edge on a pin with its rising enable set, or a falling edge with its falling enable set, sets that pin's bit in the status register (0x24). An edge is the synchronized level differing from its value one cycle earlier. An edge whose sense is not enabled sets nothing. With both enables set, either edge sets the bit.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: If an enabled edge is detected in the same cycle that software writes 1 to clear that status bit, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address within the bank |
| bus_wdata | input | NPINS (32) | Write data |
| bus_rdata | output | NPINS (32) | Read data, combinational |
| pin_in | input | NPINS (32) | Pad input levels, asynchronous |
| pin_out | output | NPINS (32) | Output latch to pads |
| pin_oe | output | NPINS (32) | Per-pin output enable |

## Verification
Two functions can act on the same status bit in the same cycle: detecting a new edge and a software write-one-to-clear. The bench changes a pin level and counts the two synchronizer flops and the previous-value flop, so that the clear write lands on the exact edge where the new event is captured. It then reads the status register and expects the bit still set. A second clear with no edge pending must then empty it. A checker property also requires that every edge detected in one cycle appears in the status register in the next cycle, whatever write is in progress.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  // Word index of each register within the bank; order is software-visible.
  localparam int unsigned REG_DIR  = 0;
  localparam int unsigned REG_OUT  = 1;
  localparam int unsigned REG_SETD = 2;
  localparam int unsigned REG_CLRD = 3;
  localparam int unsigned REG_IN   = 4;
  localparam int unsigned REG_RSET = 5;
  localparam int unsigned REG_RCLR = 6;
  localparam int unsigned REG_FSET = 7;
  localparam int unsigned REG_FCLR = 8;
  localparam int unsigned REG_STAT = 9;

  typedef struct packed {
    logic dir;
    logic out;
    logic setd;
    logic clrd;
    logic rset;
    logic rclr;
    logic fset;
    logic fclr;
    logic stat;
  } wr_strobe_t;
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output wr_strobe_t        wr_stb,
  output logic              rd_ok,
  output logic [ADDR_W-3:0] rd_idx
);
  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic             wr_ok;
  logic [IDX_W-1:0] idx;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign idx     = bus_addr[ADDR_W-1:2];
  assign wr_ok   = bus_sel && bus_wr && aligned;
  assign rd_ok   = bus_sel && !bus_wr && aligned;
  assign rd_idx  = idx;

  always_comb begin
    wr_stb.dir  = wr_ok && (idx == IDX_W'(REG_DIR));
    wr_stb.out  = wr_ok && (idx == IDX_W'(REG_OUT));
    wr_stb.setd = wr_ok && (idx == IDX_W'(REG_SETD));
    wr_stb.clrd = wr_ok && (idx == IDX_W'(REG_CLRD));
    wr_stb.rset = wr_ok && (idx == IDX_W'(REG_RSET));
    wr_stb.rclr = wr_ok && (idx == IDX_W'(REG_RCLR));
    wr_stb.fset = wr_ok && (idx == IDX_W'(REG_FSET));
    wr_stb.fclr = wr_ok && (idx == IDX_W'(REG_FCLR));
    wr_stb.stat = wr_ok && (idx == IDX_W'(REG_STAT));
  end
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_edge_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_strobe_t       wr_stb,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] out_q,
  output logic [NPINS-1:0] rise_en_q,
  output logic [NPINS-1:0] fall_en_q
);
  logic [NPINS-1:0] dir_d, out_d, rise_en_d, fall_en_d;
  logic             dir_ce, out_ce, rise_ce, fall_ce;

  assign dir_ce  = wr_stb.dir;
  assign out_ce  = wr_stb.out || wr_stb.setd || wr_stb.clrd;
  assign rise_ce = wr_stb.rset || wr_stb.rclr;
  assign fall_ce = wr_stb.fset || wr_stb.fclr;

  always_comb begin
    dir_d = wdata;
    if (wr_stb.out)       out_d = wdata;
    else if (wr_stb.setd) out_d = out_q | wdata;
    else                  out_d = out_q & ~wdata;
    rise_en_d = wr_stb.rset ? (rise_en_q | wdata) : (rise_en_q & ~wdata);
    fall_en_d = wr_stb.fset ? (fall_en_q | wdata) : (fall_en_q & ~wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '1;
      out_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
    end else begin
      if (dir_ce)  dir_q     <= dir_d;
      if (out_ce)  out_q     <= out_d;
      if (rise_ce) rise_en_q <= rise_en_d;
      if (fall_ce) fall_en_q <= fall_en_d;
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] sync_q,
  output logic [NPINS-1:0] prev_q
);
  logic [NPINS-1:0] stage_q [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= pin_in;
      for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[SYNC_STAGES-1];
    end
  end

  assign sync_q = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] sync_q,
  input  logic [NPINS-1:0] prev_q,
  input  logic [NPINS-1:0] rise_en,
  input  logic [NPINS-1:0] fall_en,
  input  logic             clr_wr,
  input  logic [NPINS-1:0] clr_mask,
  output logic [NPINS-1:0] stat_q
);
  logic [NPINS-1:0] hit, stat_d, clr_bits;

  always_comb begin
    hit      = (sync_q & ~prev_q & rise_en) | (~sync_q & prev_q & fall_en);
    clr_bits = clr_wr ? clr_mask : '0;
    // A fresh event outranks a clear arriving in the same cycle.
    stat_d   = (stat_q & ~clr_bits) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  localparam int IDX_W = ADDR_W - 2;

  wr_strobe_t       wr_stb;
  logic             rd_ok;
  logic [IDX_W-1:0] rd_idx;
  logic [NPINS-1:0] dir_q, out_q, rise_en_q, fall_en_q;
  logic [NPINS-1:0] sync_q, prev_q, stat_q;

  gpio_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .wr_stb  (wr_stb),
    .rd_ok   (rd_ok),
    .rd_idx  (rd_idx)
  );

  gpio_ctrl_regs #(.NPINS(NPINS)) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .wdata    (bus_wdata),
    .dir_q    (dir_q),
    .out_q    (out_q),
    .rise_en_q(rise_en_q),
    .fall_en_q(fall_en_q)
  );

  gpio_in_sync #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_in(pin_in),
    .sync_q(sync_q),
    .prev_q(prev_q)
  );

  gpio_edge_status #(.NPINS(NPINS)) stat_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_q  (sync_q),
    .prev_q  (prev_q),
    .rise_en (rise_en_q),
    .fall_en (fall_en_q),
    .clr_wr  (wr_stb.stat),
    .clr_mask(bus_wdata),
    .stat_q  (stat_q)
  );

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      if      (rd_idx == IDX_W'(REG_DIR))  bus_rdata = dir_q;
      else if (rd_idx == IDX_W'(REG_OUT))  bus_rdata = out_q;
      else if (rd_idx == IDX_W'(REG_SETD)) bus_rdata = out_q;
      else if (rd_idx == IDX_W'(REG_IN))   bus_rdata = sync_q;
      else if (rd_idx == IDX_W'(REG_RSET)) bus_rdata = rise_en_q;
      else if (rd_idx == IDX_W'(REG_FSET)) bus_rdata = fall_en_q;
      else if (rd_idx == IDX_W'(REG_STAT)) bus_rdata = stat_q;
    end
  end
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  rise_en_q,
  input logic [NPINS-1:0]  fall_en_q,
  input logic [NPINS-1:0]  sync_q,
  input logic [NPINS-1:0]  prev_q,
  input logic [NPINS-1:0]  stat_q
);
  localparam int IDX_W = ADDR_W - 2;

  logic             wr_any;
  logic [IDX_W-1:0] widx;
  logic [NPINS-1:0] edges, clr_req;
  logic             wr_set, wr_clr, wr_ren;

  assign wr_any  = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00);
  assign widx    = bus_addr[ADDR_W-1:2];
  assign wr_set  = wr_any && (widx == IDX_W'(2));
  assign wr_clr  = wr_any && (widx == IDX_W'(3));
  assign wr_ren  = wr_any && ((widx == IDX_W'(5)) || (widx == IDX_W'(6)));
  assign clr_req = (wr_any && (widx == IDX_W'(9))) ? bus_wdata : '0;
  assign edges   = (sync_q & ~prev_q & rise_en_q) | (~sync_q & prev_q & fall_en_q);

  // R2
  oe_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & dir_q) == '0));

  // R4
  set_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

  // R4
  clr_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((pin_out & $past(bus_wdata)) == '0));

  // R6
  rise_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ren |=> $stable(rise_en_q));

  // R10
  edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edges != '0) |=> ((stat_q & $past(edges)) == $past(edges)));

  // R9
  clear_only_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(stat_q) & ~stat_q) & ~$past(clr_req)) == '0));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .pin_oe   (pin_oe),
  .pin_out  (pin_out),
  .dir_q    (dir_q),
  .rise_en_q(rise_en_q),
  .fall_en_q(fall_en_q),
  .sync_q   (sync_q),
  .prev_q   (prev_q),
  .stat_q   (stat_q)
);

// File: tb/gpio_edge_bank_tb_top.sv
module gpio_edge_bank_tb_top;
  localparam int NPINS = 32;
  localparam int AW    = 6;
  localparam logic [AW-1:0] A_DIR = 6'h00, A_OUT = 6'h04, A_SETD = 6'h08, A_CLRD = 6'h0C,
    A_IN = 6'h10, A_RSET = 6'h14, A_RCLR = 6'h18, A_FSET = 6'h1C, A_FCLR = 6'h20, A_STAT = 6'h24;

  // {is_write, addr, wdata, expected read}
  localparam int NVEC = 17;
  localparam logic [70:0] VEC [NVEC] = '{
    {1'b1, A_OUT,  32'h0000_00F0, 32'h0},
    {1'b0, A_OUT,  32'h0,         32'h0000_00F0},
    {1'b1, A_SETD, 32'h0000_0003, 32'h0},
    {1'b0, A_SETD, 32'h0,         32'h0000_00F3},
    {1'b1, A_CLRD, 32'h0000_0030, 32'h0},
    {1'b0, A_OUT,  32'h0,         32'h0000_00C3},
    {1'b0, A_CLRD, 32'h0,         32'h0},
    {1'b1, A_DIR,  32'hFFFF_0000, 32'h0},
    {1'b0, A_DIR,  32'h0,         32'hFFFF_0000},
    {1'b1, A_RSET, 32'h0000_0101, 32'h0},
    {1'b1, A_FSET, 32'h0000_0100, 32'h0},
    {1'b0, A_RSET, 32'h0,         32'h0000_0101},
    {1'b1, A_RCLR, 32'h0000_0100, 32'h0},
    {1'b0, A_RSET, 32'h0,         32'h0000_0001},
    {1'b0, A_FSET, 32'h0,         32'h0000_0100},
    {1'b0, A_RCLR, 32'h0,         32'h0},
    {1'b0, A_FCLR, 32'h0,         32'h0}
  };

  logic             clk, rst_n, bus_sel, bus_wr;
  logic [AW-1:0]    bus_addr;
  logic [NPINS-1:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
  int n_chk, n_bad;
  logic [31:0] rd_val;

  gpio_edge_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 rd_val = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_DIR);  check("R1 dir", rd_val, 32'hFFFF_FFFF);
    rd(A_OUT);  check("R1 out", rd_val, 32'h0);
    rd(A_RSET); check("R1 rise_en", rd_val, 32'h0);
    rd(A_FSET); check("R1 fall_en", rd_val, 32'h0);
    rd(A_STAT); check("R1 status", rd_val, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);

    // R3 R4 R6 R7 table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][70]) wr(VEC[i][69:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][69:64]);
        check("R3/R4/R6/R7 table", rd_val, VEC[i][31:0]);
      end
    end

    // R2 direction drives pins
    check("R2 pin_oe", pin_oe, 32'h0000_FFFF);
    check("R2 pin_out", pin_out, 32'h0000_00C3);

    // R5 two-flop latency and ignored write
    @(negedge clk); pin_in = 32'h0000_005A;
    rd(A_IN); check("R5 after one edge", rd_val, 32'h0);
    rd(A_IN); check("R5 after two edges", rd_val, 32'h0000_005A);
    wr(A_IN, 32'hFFFF_FFFF);
    rd(A_IN); check("R5 write ignored", rd_val, 32'h0000_005A);

    @(negedge clk); pin_in = '0;
    settle();
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT); check("R9 clear all", rd_val, 32'h0);

    // R8 only enabled senses capture (bit0 rise, bit8 fall)
    @(negedge clk); pin_in = 32'h0000_0103;
    settle();
    rd(A_STAT); check("R8 rise capture", rd_val, 32'h0000_0001);
    @(negedge clk); pin_in = '0;
    settle();
    rd(A_STAT); check("R8 fall capture", rd_val, 32'h0000_0101);

    // R9 w1c: ones clear, zeros ignored
    wr(A_STAT, 32'h0000_0100);
    rd(A_STAT); check("R9 w1c", rd_val, 32'h0000_0001);
    wr(A_STAT, 32'h0);
    rd(A_STAT); check("R9 zero write", rd_val, 32'h0000_0001);

    // R8 both senses on bit4
    wr(A_RSET, 32'h10); wr(A_FSET, 32'h10);
    wr(A_STAT, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = 32'h10;
    settle();
    rd(A_STAT); check("R8 both-rise", rd_val, 32'h10);
    wr(A_STAT, 32'h10);
    rd(A_STAT); check("R9 cleared", rd_val, 32'h0);

    // R8 both senses falling; then keep bit set for collision test
    @(negedge clk); pin_in = 32'h0;
    settle();
    rd(A_STAT); check("R8 both-fall", rd_val, 32'h10);

    // R10 clear lands on the edge where a new event is captured
    @(negedge clk); pin_in = 32'h10;
    @(negedge clk);
    wr(A_STAT, 32'h10);
    rd(A_STAT); check("R10 edge beats clear", rd_val, 32'h10);
    settle();
    wr(A_STAT, 32'h10);
    rd(A_STAT); check("R10 later clear", rd_val, 32'h0);

    // R6 clear-alias on falling mask
    wr(A_FCLR, 32'h10);
    rd(A_FSET); check("R6 fall clear", rd_val, 32'h100);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule